// File: doc/BRIEF.md
# Rail Fault Interrupt Register Group

This block gathers fault events from a set of voltage rails and turns them into one active-low interrupt for a host. It serves five switching converters and four linear outputs (three low-dropout regulators plus one always-on output). For each rail it tracks three fault classes: current limit, undervoltage and overvoltage. It also tracks a single power-up-complete event, which fires when the device reaches its running state.

The fault classes are split into two groups. One group of registers covers the switchers and another covers the linear outputs. Each class has three registers: a sticky status register, a mask register, and a read-only view of the live fault levels. The analog comparators deliver one-cycle event pulses, which set status bits. The host clears a status bit by writing 1 to it. The interrupt pin goes low while any status bit is set and its mask bit is clear.

The host reaches the registers through a simple port: an address, a write strobe, write data and combinational read data. The bus bridge in front of this port and the analog comparators behind it are outside this block.

Top module: `rail_fault_irq`

## Requirements
- R1: After reset, every status register reads 0x00. The power-up-complete mask reads 0x00 (unmasked). The fault masks read all ones over their implemented bits: 0x1F for the switcher classes, 0x07 for linear current limit, and 0x0F for linear undervoltage and overvoltage. `irq_n` is high.
- R2: An event pulse sets its status bit at the next clock edge. The bit then holds until the host clears it, and later events have no further effect on it.
- R3: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A status bit never sets without an event.
- R4: If an event and a write-one-to-clear hit the same status bit in the same cycle, the event wins and the bit stays 1.
- R5: A write to a mask register stores the write data in the implemented bits, and those bits read back. Unimplemented bits read 0.
- R6: `irq_n` is registered. It is low in the cycle after some status bit is 1 while its mask bit is 0, and high in the cycle after no such bit exists.
- R7: A sense register returns the live fault level inputs and is read-only. Writing to it changes no register.
- R8: Bit positions: in the switcher registers, bit n is switcher n+1 (bits 0..4). In the linear registers, bits 0..2 are regulators 1..3. Bit 3 is the always-on output in the undervoltage and overvoltage classes, and reads 0 in the current-limit class.
- R9: The power-up-complete status and mask live in bit 3 of their registers, and all other bits read 0. Because this event is unmasked after reset, it drives the interrupt with no setup.
- R10: Address map (5-bit address). 0 is power-up status and 1 is power-up mask. Class k (1 = switcher current limit, 2 = switcher undervoltage, 3 = switcher overvoltage, 4 = linear current limit, 5 = linear undervoltage, 6 = linear overvoltage) has its status at 3k-1, its mask at 3k and its sense at 3k+1. Addresses 20..31 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pwrup_done_evt | input | 1 | Power-up-complete event pulse |
| buck_ilim_evt | input | 5 | Switcher current-limit event pulses |
| buck_uv_evt | input | 5 | Switcher undervoltage event pulses |
| buck_ov_evt | input | 5 | Switcher overvoltage event pulses |
| lin_ilim_evt | input | 3 | Linear regulator current-limit event pulses |
| lin_uv_evt | input | 4 | Linear/always-on undervoltage event pulses |
| lin_ov_evt | input | 4 | Linear/always-on overvoltage event pulses |
| buck_ilim_lvl | input | 5 | Live switcher current-limit levels |
| buck_uv_lvl | input | 5 | Live switcher undervoltage levels |
| buck_ov_lvl | input | 5 | Live switcher overvoltage levels |
| lin_ilim_lvl | input | 3 | Live linear current-limit levels |
| lin_uv_lvl | input | 4 | Live linear/always-on undervoltage levels |
| lin_ov_lvl | input | 4 | Live linear/always-on overvoltage levels |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can land on the same status bit in one clock: a rail event setting the bit and a host write clearing it. The directed part of the bench drives an event pulse and a write of 1 to the same bit in the same cycle, then reads the register back and expects the bit still set. The random part pulses events while it writes arbitrary data to the status addresses, so this collision also happens many times without being arranged. Every readback and every interrupt level is compared against a bench model that applies the clear first and the event second.

// File: rtl/rail_fault_pkg.sv
package rail_fault_pkg;

  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 5;
  localparam int NUM_BUCK    = 5;
  localparam int NUM_LIN     = 3;
  localparam int NUM_LIN_AON = NUM_LIN + 1;
  localparam int NUM_BANKS   = 7;
  localparam int PWRUP_BIT   = 3;

  // bank order: 0 power-up, 1..3 switcher ilim/uv/ov, 4..6 linear ilim/uv/ov
  typedef logic [DATA_W-1:0] lane_t;

  function automatic lane_t low_ones(input int n);
    return lane_t'((1 << n) - 1);
  endfunction

  function automatic lane_t bank_valid(input int b);
    lane_t v;
    case (b)
      0:       v = lane_t'(1 << PWRUP_BIT);
      1, 2, 3: v = low_ones(NUM_BUCK);
      4:       v = low_ones(NUM_LIN);
      default: v = low_ones(NUM_LIN_AON);
    endcase
    return v;
  endfunction

  function automatic lane_t bank_mask_rst(input int b);
    return (b == 0) ? lane_t'(0) : bank_valid(b);
  endfunction

  function automatic logic [ADDR_W-1:0] bank_base(input int b);
    return (b == 0) ? '0 : ADDR_W'(3 * b - 1);
  endfunction

endpackage

// File: rtl/rail_fault_bank.sv
module rail_fault_bank #(
  parameter int              W        = 8,
  parameter logic [W-1:0]    VALID    = '1,
  parameter logic [W-1:0]    MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         wr_stat_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);

  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] mask_q, mask_d;
  logic         stat_en, mask_en;

  // next state: clear first, event last so a same-cycle event survives
  always_comb begin
    stat_en = wr_stat_i | (|(evt_i & VALID));
    stat_d  = stat_q;
    if (wr_stat_i) begin
      stat_d = stat_d & ~wdata_i;
    end
    stat_d  = (stat_d | evt_i) & VALID;
    mask_en = wr_mask_i;
    mask_d  = wdata_i & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);

endmodule

// File: rtl/rail_fault_regmux.sv
module rail_fault_regmux
  import rail_fault_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic [NB-1:0][DATA_W-1:0]  stat_i,
  input  logic [NB-1:0][DATA_W-1:0]  mask_i,
  input  logic [NB-1:1][DATA_W-1:0]  sense_i,
  output logic [NB-1:0]              wr_stat_o,
  output logic [NB-1:0]              wr_mask_o,
  output logic [DATA_W-1:0]          rdata_o
);

  always_comb begin
    logic [ADDR_W-1:0] base;
    wr_stat_o = '0;
    wr_mask_o = '0;
    rdata_o   = '0;
    for (int b = 0; b < NB; b++) begin
      base = bank_base(b);
      if (addr_i == base) begin
        wr_stat_o[b] = wr_i;
        rdata_o      = stat_i[b];
      end
      if (addr_i == base + ADDR_W'(1)) begin
        wr_mask_o[b] = wr_i;
        rdata_o      = mask_i[b];
      end
      if (b > 0 && addr_i == base + ADDR_W'(2)) begin
        rdata_o = sense_i[(b > 0) ? b : 1] & bank_valid(b);
      end
    end
  end

endmodule

// File: rtl/rail_irq_drive.sv
module rail_irq_drive #(
  parameter int NB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] pend_i,
  output logic          irq_n_o
);

  logic irq_n_q, irq_n_d;

  always_comb begin
    irq_n_d = ~(|pend_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n_o = irq_n_q;

endmodule

// File: rtl/rail_fault_irq.sv
module rail_fault_irq
  import rail_fault_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic                   pwrup_done_evt,
  input  logic [NUM_BUCK-1:0]    buck_ilim_evt,
  input  logic [NUM_BUCK-1:0]    buck_uv_evt,
  input  logic [NUM_BUCK-1:0]    buck_ov_evt,
  input  logic [NUM_LIN-1:0]     lin_ilim_evt,
  input  logic [NUM_LIN_AON-1:0] lin_uv_evt,
  input  logic [NUM_LIN_AON-1:0] lin_ov_evt,
  input  logic [NUM_BUCK-1:0]    buck_ilim_lvl,
  input  logic [NUM_BUCK-1:0]    buck_uv_lvl,
  input  logic [NUM_BUCK-1:0]    buck_ov_lvl,
  input  logic [NUM_LIN-1:0]     lin_ilim_lvl,
  input  logic [NUM_LIN_AON-1:0] lin_uv_lvl,
  input  logic [NUM_LIN_AON-1:0] lin_ov_lvl,
  output logic                   irq_n
);

  localparam int NB = NUM_BANKS;

  logic [1:0]                rst_sync_q;
  logic                      rst_q_n;
  logic [NB-1:0][DATA_W-1:0] evt8;
  logic [NB-1:0][DATA_W-1:0] stat8;
  logic [NB-1:0][DATA_W-1:0] mask8;
  logic [NB-1:1][DATA_W-1:0] sense8;
  logic [NB-1:0]             wr_stat, wr_mask, pend;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  always_comb begin
    evt8                     = '0;
    evt8[0][PWRUP_BIT]       = pwrup_done_evt;
    evt8[1][NUM_BUCK-1:0]    = buck_ilim_evt;
    evt8[2][NUM_BUCK-1:0]    = buck_uv_evt;
    evt8[3][NUM_BUCK-1:0]    = buck_ov_evt;
    evt8[4][NUM_LIN-1:0]     = lin_ilim_evt;
    evt8[5][NUM_LIN_AON-1:0] = lin_uv_evt;
    evt8[6][NUM_LIN_AON-1:0] = lin_ov_evt;
  end

  always_comb begin
    sense8                     = '0;
    sense8[1][NUM_BUCK-1:0]    = buck_ilim_lvl;
    sense8[2][NUM_BUCK-1:0]    = buck_uv_lvl;
    sense8[3][NUM_BUCK-1:0]    = buck_ov_lvl;
    sense8[4][NUM_LIN-1:0]     = lin_ilim_lvl;
    sense8[5][NUM_LIN_AON-1:0] = lin_uv_lvl;
    sense8[6][NUM_LIN_AON-1:0] = lin_ov_lvl;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    rail_fault_bank #(
      .W        (DATA_W),
      .VALID    (bank_valid(b)),
      .MASK_RST (bank_mask_rst(b))
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .evt_i     (evt8[b]),
      .wr_stat_i (wr_stat[b]),
      .wr_mask_i (wr_mask[b]),
      .wdata_i   (reg_wdata),
      .stat_o    (stat8[b]),
      .mask_o    (mask8[b]),
      .pend_o    (pend[b])
    );
  end

  rail_fault_regmux #(.NB(NB)) u_regmux (
    .addr_i    (reg_addr),
    .wr_i      (reg_wr),
    .stat_i    (stat8),
    .mask_i    (mask8),
    .sense_i   (sense8),
    .wr_stat_o (wr_stat),
    .wr_mask_o (wr_mask),
    .rdata_o   (reg_rdata)
  );

  rail_irq_drive #(.NB(NB)) u_irq (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .pend_i  (pend),
    .irq_n_o (irq_n)
  );

endmodule

// File: rtl/rail_fault_irq_chk.sv
module rail_fault_irq_chk #(
  parameter int NB = 7
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 irq_n,
  input logic [NB-1:0][7:0]   evt8,
  input logic [NB-1:0][7:0]   stat8,
  input logic [NB-1:0]        pend
);

  // R1: while reset holds, status is clear and the interrupt is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_ni |=> (irq_n && stat8 == '0));

  // R6: pending bank drives irq_n low one cycle later
  p_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (|pend) |=> !irq_n);

  // R6: no pending bank releases irq_n one cycle later
  p_irq_high_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(|pend) |=> irq_n);

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    // R2 and R4: every pulsed bit is set next cycle, even under a clear
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      (evt8[b] != 8'h00) |=> ((stat8[b] & $past(evt8[b])) == $past(evt8[b])));

    // R3: no status bit rises without an event
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      (stat8[b] & ~$past(stat8[b]) & ~$past(evt8[b])) == 8'h00);
  end

endmodule

bind rail_fault_irq rail_fault_irq_chk #(.NB(NB)) u_chk (
  .clk    (clk),
  .rst_ni (rst_q_n),
  .irq_n  (irq_n),
  .evt8   (evt8),
  .stat8  (stat8),
  .pend   (pend)
);

// File: tb/tb_rail_fault_irq.sv
module tb_rail_fault_irq;
  import rail_fault_pkg::*;

  localparam int CLK_PERIOD_NS = 10;
  localparam int NB            = 7;
  localparam int RAND_CYCLES   = 3000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_n;
  logic [7:0] ev [NB];
  logic [7:0] lv [NB];

  logic [7:0] st [NB];
  logic [7:0] mk [NB];
  logic [7:0] wm [NB];
  logic       exp_irq_n;
  int         checks = 0;
  int         failures = 0;
  bit         done = 0;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  rail_fault_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwrup_done_evt(ev[0][3]),
    .buck_ilim_evt(ev[1][4:0]), .buck_uv_evt(ev[2][4:0]), .buck_ov_evt(ev[3][4:0]),
    .lin_ilim_evt(ev[4][2:0]), .lin_uv_evt(ev[5][3:0]), .lin_ov_evt(ev[6][3:0]),
    .buck_ilim_lvl(lv[1][4:0]), .buck_uv_lvl(lv[2][4:0]), .buck_ov_lvl(lv[3][4:0]),
    .lin_ilim_lvl(lv[4][2:0]), .lin_uv_lvl(lv[5][3:0]), .lin_ov_lvl(lv[6][3:0]),
    .irq_n(irq_n)
  );

  function automatic logic [4:0] base_of(int b);
    return (b == 0) ? 5'd0 : 5'(3 * b - 1);
  endfunction

  function automatic logic [7:0] model_read(logic [4:0] a);
    for (int b = 0; b < NB; b++) begin
      if (a == base_of(b)) return st[b];
      if (a == base_of(b) + 5'd1) return mk[b];
      if (b > 0 && a == base_of(b) + 5'd2) return lv[b] & wm[b];
    end
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one clock: read check before the edge, model update at the edge, irq check after
  task automatic cycle(logic [4:0] a, logic wr, logic [7:0] wd, string req);
    logic pend_old;
    reg_addr = a; reg_wr = wr; reg_wdata = wd;
    #1;
    check(req, reg_rdata, model_read(a));
    @(posedge clk);
    pend_old = 1'b0;
    for (int b = 0; b < NB; b++) pend_old |= |(st[b] & ~mk[b]);
    exp_irq_n = ~pend_old;
    for (int b = 0; b < NB; b++) begin
      if (wr && a == base_of(b)) st[b] = st[b] & ~wd;
      if (wr && a == base_of(b) + 5'd1) mk[b] = wd & wm[b];
      st[b] = st[b] | (ev[b] & wm[b]);
    end
    @(negedge clk);
    for (int b = 0; b < NB; b++) ev[b] = 8'h00;
    reg_wr = 1'b0;
    check("R6 irq_n", {7'd0, irq_n}, {7'd0, exp_irq_n});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    wm[0] = 8'h08; wm[1] = 8'h1F; wm[2] = 8'h1F; wm[3] = 8'h1F;
    wm[4] = 8'h07; wm[5] = 8'h0F; wm[6] = 8'h0F;
    for (int b = 0; b < NB; b++) begin
      ev[b] = 8'h00; lv[b] = 8'h00; st[b] = 8'h00;
      mk[b] = (b == 0) ? 8'h00 : wm[b];
    end
    exp_irq_n = 1'b1;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values of every status and mask register
    for (int b = 0; b < NB; b++) begin
      cycle(base_of(b), 1'b0, 8'h00, "R1 status");
      cycle(base_of(b) + 5'd1, 1'b0, 8'h00, "R1 mask");
    end

    // R9: power-up event lands in bit 3 and interrupts while unmasked
    ev[0] = 8'h08;
    cycle(5'd0, 1'b0, 8'h00, "R9");
    cycle(5'd0, 1'b0, 8'h00, "R9 status bit3");
    cycle(5'd0, 1'b1, 8'hF7, "R3 write zero keeps");
    cycle(5'd0, 1'b1, 8'h08, "R3 clear");
    cycle(5'd0, 1'b0, 8'h00, "R3 cleared");

    // R4: event and clear of the same bit in one cycle
    ev[1] = 8'h01;
    cycle(5'd2, 1'b0, 8'h00, "R2");
    ev[1] = 8'h01;
    cycle(5'd2, 1'b1, 8'h01, "R4 before");
    cycle(5'd2, 1'b0, 8'h00, "R4 event wins");
    cycle(5'd3, 1'b1, 8'hFE, "R5 unmask sw1");
    cycle(5'd3, 1'b0, 8'h00, "R5 mask readback");
    cycle(5'd2, 1'b1, 8'h01, "R6 clear pending");
    cycle(5'd2, 1'b0, 8'h00, "R6 after clear");

    // R7: sense is live and read-only
    lv[1] = 8'h15; lv[5] = 8'h0A;
    cycle(5'd4, 1'b1, 8'hFF, "R7 sense live");
    cycle(5'd4, 1'b0, 8'h00, "R7 sense after write");
    cycle(5'd2, 1'b0, 8'h00, "R7 status untouched");
    cycle(5'd16, 1'b0, 8'h00, "R7 lin uv sense");

    // R8: always-on bit and linear current-limit width
    ev[5] = 8'h08; ev[6] = 8'h04;
    cycle(5'd14, 1'b0, 8'h00, "R8");
    cycle(5'd14, 1'b0, 8'h00, "R8 aon uv bit3");
    cycle(5'd17, 1'b0, 8'h00, "R8 ldo3 ov bit2");
    cycle(5'd12, 1'b1, 8'hFF, "R8 lin ilim mask write");
    cycle(5'd12, 1'b0, 8'h00, "R8 lin ilim mask bit3 zero");

    // R10: unmapped addresses
    cycle(5'd25, 1'b1, 8'hFF, "R10 unmapped");
    cycle(5'd20, 1'b1, 8'hFF, "R10 unmapped");
    cycle(5'd31, 1'b0, 8'h00, "R10 unmapped");

    // random mix, including event and clear collisions
    for (int i = 0; i < RAND_CYCLES; i++) begin
      for (int b = 0; b < NB; b++) begin
        if (($urandom % 6) == 0) ev[b] = 8'($urandom) & wm[b];
      end
      if (($urandom % 32) == 0) begin
        for (int b = 1; b < NB; b++) lv[b] = 8'($urandom) & wm[b];
      end
      cycle(5'($urandom % 24), (($urandom % 3) == 0), 8'($urandom), "R2 R3 R5 R10 random");
    end

    done = 1;
    finish_run();
  end

endmodule